// File: doc/BRIEF.md
# Busy-Indicator Serial Converter Interface

This block models the digital side of a successive-approximation converter that talks to a host over a four-wire serial link and signals the end of each conversion on its data-out line. A rising edge on the convert pin starts a fixed-length conversion. When it finishes and the convert pin is low, the data-out line leaves high impedance and is driven low. The host can use that low level as an interrupt. The host then clocks the serial clock. Falling edges shift out the result, most significant bit first. If the configuration that governed that conversion asked for readback, that configuration word follows the result. Rising edges during the same window load a new 14-bit configuration word from the data-in pin.

All pins are sampled by the system clock. Edges on the convert and serial clock pins are found by comparing each pin with its value one clock earlier, so the serial clock must stay at each level for at least two system clocks. The analog core is replaced by a parallel sample input, which is captured in the cycle the conversion ends. The data-out line is modelled as a value plus an output enable.

Top module: `adc_busy_serial_if`

## Requirements
- R1: An accepted rising edge of `cnv_i` starts a conversion and disables `sdo_oe_o` on the next clock, which also discards the previous result. Rising edges of `sck_i` while a conversion runs do not change the configuration.
- R2: A conversion lasts exactly CONV_CYCLES system clocks whatever `cnv_i` does. With `cnv_i` low, `sdo_oe_o` rises CONV_CYCLES clocks after the clock that registered the start edge.
- R3: At conversion end with `cnv_i` low, `sdo_oe_o` goes high with `sdo_o` = 0. If `cnv_i` is still high, this happens on the first clock that sees `cnv_i` low.
- R4: While idle with `cnv_i` low, the first CFG_W rising edges of `sck_i` shift `din_i` into a pending configuration, first bit received = bit 13. Further rising edges are ignored.
- R5: If fewer than CFG_W bits were received when the next conversion starts, the pending word is discarded and the active configuration is kept.
- R6: Falling edges 1 to 16 of `sck_i` put result bits 15 down to 0 on `sdo_o`. The result is `sample_i` as captured on the last clock of the conversion.
- R7: If bit 0 of the configuration used by a conversion is 1, falling edges 17 to 30 put that configuration's bits 13 down to 0 on `sdo_o`, and falling edge 31 disables `sdo_oe_o`.
- R8: If that bit 0 is 0, falling edge 17 disables `sdo_oe_o`.
- R9: If fewer falling edges arrive than needed to end the frame, the last driven bit stays on `sdo_o` with `sdo_oe_o` high until the next conversion starts.
- R10: A rising edge of `cnv_i` during a conversion is ignored and neither restarts nor extends it.
- R11: A complete configuration word takes effect from the next conversion onward. After reset the configuration is CFG_RESET, whose default 0 disables readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_i | input | 1 | Convert pin; rising edge starts a conversion |
| sck_i | input | 1 | Serial clock from the host, idle high |
| din_i | input | 1 | Serial configuration data from the host |
| sample_i | input | DATA_W | Stand-in for the converter core's result |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable of the serial data line; 0 means high impedance |

## Verification
The bench builds the block with CONV_CYCLES set to 80 and keeps the 16-bit result and 14-bit configuration widths. That conversion time is long enough for fourteen complete serial clock periods to fit inside a conversion, so the bench can show that data-in is ignored while a conversion is busy. It also leaves room to toggle the convert pin several times inside one conversion. Random frames of 0 to 34 edges, mixed with directed cases, cover the end-of-frame point for both readback settings, held last bits and discarded partial writes.

// File: rtl/adc_if_pkg.sv
// Package: shared constants of the busy-indicator serial converter interface.
// Assumes: nothing; holds only values that every unit agrees on.
package adc_if_pkg;
    // Position of the readback-enable flag inside the configuration word.
    localparam int RB_BIT = 0;
    // Minimum number of system clocks a conversion may last.
    localparam int MIN_CONV_CYCLES = 2;
endpackage

// File: rtl/adc_conv_timer.sv
// Module: conversion timer.
// Starts on a start request while idle and runs for CONV_CYCLES clocks,
// whatever happens on the request line. It raises done_o on the last cycle.
// Assumes: CONV_CYCLES >= MIN_CONV_CYCLES.
module adc_conv_timer #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req_i,
    output logic start_o,
    output logic busy_o,
    output logic done_o
);
    import adc_if_pkg::*;

    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // A start request counts only while idle.
    assign start_o = start_req_i && !busy_q;
    assign busy_o  = busy_q;
    assign done_o  = busy_q && (cnt_q == LAST);

    // Busy flag and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    initial begin
        if (CONV_CYCLES < MIN_CONV_CYCLES) $error("CONV_CYCLES too small");
    end

    // R2: a running conversion continues until its last cycle.
    p_runs_to_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done_o |=> busy_q);

    // R10: a start request during a conversion does not restart the count.
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done_o && start_req_i |=> cnt_q == $past(cnt_q) + 1'b1);

    // R2: the counter never passes the last cycle.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/adc_cfg_shifter.sv
// Module: configuration receiver.
// Shifts data-in on accepted serial clock rising edges into a pending word.
// At a conversion start it promotes the pending word only if all CFG_W bits
// arrived, then latches the configuration used by that conversion.
// Assumes: rise_i is already qualified (idle and convert pin low).
module adc_cfg_shifter #(
    parameter int          CFG_W     = 14,
    parameter logic [13:0] CFG_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             busy_i,
    input  logic             rise_i,
    input  logic             din_i,
    output logic [CFG_W-1:0] conv_cfg_o
);
    localparam int WW = $clog2(CFG_W + 1);
    localparam logic [WW-1:0] FULL = WW'(CFG_W);

    logic [CFG_W-1:0] shift_q;
    logic [CFG_W-1:0] act_q;
    logic [CFG_W-1:0] conv_q;
    logic [WW-1:0]    wr_cnt_q;
    logic [CFG_W-1:0] next_act;

    // The configuration that the starting conversion will use.
    always_comb begin
        next_act = (wr_cnt_q == FULL) ? shift_q : act_q;
    end

    // Pending shift register and its bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            wr_cnt_q <= '0;
        end else if (start_i) begin
            wr_cnt_q <= '0;
        end else if (rise_i && !busy_i && wr_cnt_q != FULL) begin
            shift_q  <= {shift_q[CFG_W-2:0], din_i};
            wr_cnt_q <= wr_cnt_q + 1'b1;
        end
    end

    // Active configuration and the copy bound to the running conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= CFG_RESET[CFG_W-1:0];
            conv_q <= CFG_RESET[CFG_W-1:0];
        end else if (start_i) begin
            act_q  <= next_act;
            conv_q <= next_act;
        end
    end

    assign conv_cfg_o = conv_q;

    // R4: no more than CFG_W bits are ever counted.
    p_wr_cnt_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_q <= FULL);

    // R1: data-in is ignored while a conversion runs.
    p_din_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(shift_q));

    // R5: the active configuration changes only at a conversion start.
    p_act_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(act_q));
endmodule

// File: rtl/adc_sdo_serializer.sv
// Module: data-out serializer.
// Captures the result at conversion end and drives the busy-done low level.
// It then presents result bits, and the configuration when readback is on,
// on serial clock falling edges. It releases the line after the frame.
// Assumes: fall_i is a one-cycle pulse per falling edge.
module adc_sdo_serializer #(
    parameter int DATA_W = 16,
    parameter int CFG_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              done_i,
    input  logic              cnv_i,
    input  logic              fall_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [CFG_W-1:0]  conv_cfg_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    import adc_if_pkg::*;

    localparam int FRAME_W = DATA_W + CFG_W;
    localparam int FW      = $clog2(FRAME_W + 2);
    localparam logic [FW-1:0] STOP_DATA  = FW'(DATA_W);
    localparam logic [FW-1:0] STOP_FRAME = FW'(FRAME_W);

    logic [DATA_W-1:0]  result_q;
    logic [CFG_W-1:0]   rcfg_q;
    logic [FRAME_W-1:0] frame_q;
    logic [FW-1:0]      fall_cnt_q;
    logic               armed_q;
    logic               oe_q;
    logic               sdo_q;
    logic               rb_q;
    logic [DATA_W-1:0]  fresh_res;
    logic [CFG_W-1:0]   fresh_cfg;
    logic [FW-1:0]      stop_cnt;
    logic               enable_now;

    // Use the values captured this cycle when the conversion ends now.
    always_comb begin
        fresh_res  = done_i ? sample_i : result_q;
        fresh_cfg  = done_i ? conv_cfg_i : rcfg_q;
        stop_cnt   = rb_q ? STOP_FRAME : STOP_DATA;
        enable_now = (done_i || armed_q) && !cnv_i;
    end

    // Result and its configuration captured at conversion end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            rcfg_q   <= '0;
        end else if (done_i) begin
            result_q <= sample_i;
            rcfg_q   <= conv_cfg_i;
        end
    end

    // Line control: release on start, busy-done low, then frame shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q       <= 1'b0;
            sdo_q      <= 1'b0;
            armed_q    <= 1'b0;
            rb_q       <= 1'b0;
            fall_cnt_q <= '0;
            frame_q    <= '0;
        end else if (start_i) begin
            oe_q    <= 1'b0;
            sdo_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (enable_now) begin
            oe_q       <= 1'b1;
            sdo_q      <= 1'b0;
            armed_q    <= 1'b0;
            fall_cnt_q <= '0;
            frame_q    <= {fresh_res, fresh_cfg};
            rb_q       <= fresh_cfg[RB_BIT];
        end else if (done_i) begin
            armed_q <= 1'b1;
        end else if (oe_q && fall_i && !cnv_i) begin
            if (fall_cnt_q == stop_cnt) begin
                oe_q <= 1'b0;
            end else begin
                sdo_q   <= frame_q[FRAME_W-1];
                frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
            end
            fall_cnt_q <= fall_cnt_q + 1'b1;
        end
    end

    assign sdo_o    = sdo_q;
    assign sdo_oe_o = oe_q;

    // R3: the line always turns on at the busy-done low level.
    p_busy_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !sdo_q);

    // R1: a conversion start releases the line on the next clock.
    p_hiz_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !oe_q);

    // R7: the falling-edge count never exceeds the longest frame.
    p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> fall_cnt_q <= STOP_FRAME);

    // R9: without a falling edge or start, a driven line keeps its bit.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q && !fall_i && !start_i && !done_i && !armed_q |=> oe_q && $stable(sdo_q));
endmodule

// File: rtl/adc_busy_serial_if.sv
// Module: top of the busy-indicator serial converter interface.
// Registers the convert and serial clock pins to find their edges. It wires
// the conversion timer, configuration receiver and data-out serializer.
// Assumes: pins are stable for at least two system clocks per level.
module adc_busy_serial_if #(
    parameter int          DATA_W      = 16,
    parameter int          CFG_W       = 14,
    parameter int          CONV_CYCLES = 40,
    parameter logic [13:0] CFG_RESET   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic              sck_i,
    input  logic              din_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    logic cnv_q;
    logic sck_q;
    logic cnv_rise;
    logic sck_rise;
    logic sck_fall;
    logic start;
    logic busy;
    logic done;
    logic [CFG_W-1:0] conv_cfg;

    // Previous pin levels; idle-high reset avoids a false edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_q <= 1'b1;
            sck_q <= 1'b1;
        end else begin
            cnv_q <= cnv_i;
            sck_q <= sck_i;
        end
    end

    // Edge pulses.
    always_comb begin
        cnv_rise = cnv_i && !cnv_q;
        sck_rise = sck_i && !sck_q && !cnv_i;
        sck_fall = !sck_i && sck_q;
    end

    adc_conv_timer #(
        .CONV_CYCLES(CONV_CYCLES)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req_i(cnv_rise),
        .start_o    (start),
        .busy_o     (busy),
        .done_o     (done)
    );

    adc_cfg_shifter #(
        .CFG_W    (CFG_W),
        .CFG_RESET(CFG_RESET)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .busy_i    (busy),
        .rise_i    (sck_rise),
        .din_i     (din_i),
        .conv_cfg_o(conv_cfg)
    );

    adc_sdo_serializer #(
        .DATA_W(DATA_W),
        .CFG_W (CFG_W)
    ) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .done_i    (done),
        .cnv_i     (cnv_i),
        .fall_i    (sck_fall),
        .sample_i  (sample_i),
        .conv_cfg_i(conv_cfg),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o)
    );

    // R10: a start is never accepted while a conversion runs.
    p_one_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: tb/adc_busy_serial_if_tb.sv
// Bench: directed corner cases plus seeded random frames, checked against
// a reference model of the configuration and frame rules.
module adc_busy_serial_if_tb_top;
    localparam int C = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv = 1'b0;
    logic        sck = 1'b1;
    logic        din = 1'b0;
    logic [15:0] sample = '0;
    logic        sdo;
    logic        sdo_oe;

    int n_tests = 0;
    int n_fail  = 0;

    logic [13:0] act_cfg;
    logic [13:0] pend_word;
    logic        pend_ok;
    logic [13:0] cur_cfg;
    logic [15:0] cur_res;

    always #2.5 clk = ~clk;

    adc_busy_serial_if #(
        .DATA_W(16), .CFG_W(14), .CONV_CYCLES(C), .CFG_RESET(14'h0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .din_i(din),
        .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual oe/sdo=%b expected=%b", req, act, exp);
        end
    endtask

    // Expected {oe,sdo} after falling edge k of a frame.
    function automatic logic [1:0] exp_fall(input int k, input logic [15:0] res,
                                            input logic [13:0] cfg);
        if (k <= 16) return {1'b1, res[16-k]};
        if (cfg[0] && k <= 30) return {1'b1, cfg[30-k]};
        return 2'b00;
    endfunction

    // Reference model update at an accepted start.
    task automatic model_start();
        if (pend_ok) act_cfg = pend_word;
        pend_ok = 1'b0;
        cur_cfg = act_cfg;
    endtask

    // Start a conversion with a short convert pulse; check R1, R2, R3 timing.
    task automatic conv(input logic [15:0] s);
        cnv = 1'b1;
        sample = s;
        model_start();
        @(negedge clk);
        check("R1 hi-Z after start", {sdo_oe, 1'b0}, 2'b00);
        cnv = 1'b0;
        repeat (C - 1) @(negedge clk);
        check("R2 still busy at C-1", {sdo_oe, 1'b0}, 2'b00);
        @(negedge clk);
        check("R3 busy-done low", {sdo_oe, sdo}, 2'b10);
        cur_res = s;
    endtask

    // Run a frame of n serial clock periods writing word; check every bit.
    task automatic frame(input int n, input logic [13:0] word, input string tag);
        logic [1:0] last;
        last = 2'b10;
        for (int k = 1; k <= n; k++) begin
            din = (k <= 14) ? word[14-k] : 1'($urandom);
            sck = 1'b0;
            @(negedge clk);
            @(negedge clk);
            last = exp_fall(k, cur_res, cur_cfg);
            check({tag, " R6/R7/R8 frame bit"}, {sdo_oe, sdo_oe ? sdo : 1'b0},
                  {last[1], last[1] ? last[0] : 1'b0});
            sck = 1'b1;
            @(negedge clk);
            @(negedge clk);
        end
        if (n >= 14) begin
            pend_word = word;
            pend_ok   = 1'b1;
        end
        repeat (10) @(negedge clk);
        check({tag, " R9 hold after frame"}, {sdo_oe, sdo_oe ? sdo : 1'b0},
              {last[1], last[1] ? last[0] : 1'b0});
    endtask

    initial begin
        void'($urandom(32'd1234));
        act_cfg = 14'h0; pend_ok = 1'b0; pend_word = '0;
        cur_cfg = '0; cur_res = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset state", {sdo_oe, 1'b0}, 2'b00);

        // R11/R8: reset configuration has readback off; write a full word.
        conv(16'hA5C3);
        frame(17, 14'h2A5B, "d1");
        // R7/R11: the new word (bit 0 set) governs this conversion.
        conv(16'h3C96);
        frame(31, 14'h1556, "d2");
        // R9: partial write of ten bits, short frame.
        conv(16'h0F0F);
        frame(10, 14'h3FFF, "d3");
        // R5: the partial word is discarded; 1556 keeps readback off.
        conv(16'hF00D);
        frame(20, 14'h0001, "d4");

        // R10/R2: extra convert edges inside the conversion; sample changes.
        cnv = 1'b1; sample = 16'h1111; model_start();
        @(negedge clk); cnv = 1'b0;
        repeat (3) @(negedge clk); cnv = 1'b1;
        repeat (3) @(negedge clk); cnv = 1'b0; sample = 16'h8E71;
        repeat (C - 7) @(negedge clk);
        check("R10 no restart before end", {sdo_oe, 1'b0}, 2'b00);
        @(negedge clk);
        check("R10 end at original time", {sdo_oe, sdo}, 2'b10);
        cur_res = 16'h8E71;
        frame(31, 14'h2001, "d5");

        // R3: convert pin held high past the end; enable follows its fall.
        cnv = 1'b1; sample = 16'h4B2D; model_start();
        repeat (C + 2) @(negedge clk);
        check("R3 no enable while cnv high", {sdo_oe, 1'b0}, 2'b00);
        cnv = 1'b0;
        @(negedge clk);
        check("R3 enable after cnv low", {sdo_oe, sdo}, 2'b10);
        cur_res = 16'h4B2D;
        frame(31, 14'h0000, "d6");

        // R1: serial clock edges during a conversion do not write.
        cnv = 1'b1; sample = 16'h7777; model_start();
        @(negedge clk); cnv = 1'b0;
        for (int k = 0; k < 14; k++) begin
            din = 1'b1; sck = 1'b0;
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
        end
        check("R1 hi-Z during conversion", {sdo_oe, 1'b0}, 2'b00);
        repeat (C) @(negedge clk);
        cur_res = 16'h7777;
        frame(5, 14'h0000, "d7");
        // R1: these five edges leave the word incomplete; config stays 0.
        conv(16'hC001);
        frame(17, 14'h0000, "d8");

        // Random frames.
        for (int it = 0; it < 40; it++) begin
            conv(16'($urandom));
            frame(int'($urandom_range(0, 34)), 14'($urandom), "rnd");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule